// File: doc/BRIEF.md
# Multi-Modulus Modular Squarer

This combinational block squares one operand and reduces the result modulo 2^n, 2^n−1 or 2^n+1. A 2-bit select picks the modulus. All three moduli share one datapath, which serves residue-number-system channels whose moduli follow the pattern 2^n−1, 2^n, 2^n+1. The partial-product generator wires every bit whose column is the same for every modulus straight into the reduction rows. Only the bits that fold above weight 2^(n−1) pass through a per-bit multiplexer. That multiplexer drops the bit for 2^n, passes it unchanged for 2^n−1, and inverts it for 2^n+1.

The rows are summed by a chain of carry-save stages. Each stage has a multiplexer on the carry that leaves the top column. For 2^n the carry is discarded. For 2^n−1 it re-enters the lowest column unchanged, and for 2^n+1 it re-enters inverted. The inverted bits and inverted carries each leave a known offset. In 2^n+1 mode one constant row, derived from n at elaboration, cancels all of those offsets; it is forced to zero in the other modes. A prefix adder with a reinsertion multiplexer on its carry-out then produces the canonical residue.

The operand is n+1 bits wide so that the value 2^n can be presented in 2^n+1 mode. It uses ordinary weighted binary coding. The width n is a parameter, legal from 3 to 30.

Top module: `sq_multimod`

## Requirements
- R1: With select code 00, the output equals the low n bits of the square of the operand's low n bits, and output bit n is 0.
- R2: With select code 01, the output equals the square of the operand's low n bits modulo 2^n−1, always in the range 0 to 2^n−2. An all-ones operand gives 0.
- R3: With select code 10 and an operand from 0 to 2^n inclusive (n+1 bits, weighted binary), the output equals the operand squared modulo 2^n+1. An operand of exactly 2^n gives 1.
- R4: Select code 11 is reserved, and the output is all zeros for every operand.
- R5: Operand bit n has no effect on the output under select codes 00 and 01.
- R6: Output bit n is 1 only under select code 10 and only when the residue is exactly 2^n; the low n output bits are then all zero.
- R7: The block holds no state. The output follows the current select and operand with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mod_sel | input | 2 | Modulus select: 00 → 2^n, 01 → 2^n−1, 10 → 2^n+1, 11 reserved |
| operand | input | N+1 | Value to square; bit N is used only under select code 10 |
| square | output | N+1 | Canonical residue of the square under the selected modulus |

## Verification
The bench builds two copies of the block, one with n = 5 and one with n = 4. At these widths every operand value in every select code can be applied and compared with a plain modulo reference, including the operand values with bit n set. The n = 4 copy reaches the case where the 2^n+1 residue is exactly 2^n, so output bit n is set, because 17 has square roots of −1. The n = 5 copy has no such case. Its odd width drives the correction constant and the folding pattern through the other parity.

// File: rtl/sq_mm_pkg.sv
package sq_mm_pkg;

   typedef enum logic [1:0] {
      SQ_POW2  = 2'b00,
      SQ_MINUS = 2'b01,
      SQ_PLUS  = 2'b10,
      SQ_RSVD  = 2'b11
   } sq_mode_e;

   // Value placed in a column after folding from weight 2^(n+k) down to 2^k
   function automatic logic fold_bit(input logic v, input sq_mode_e m);
      case (m)
         SQ_MINUS: return v;
         SQ_PLUS:  return ~v;
         default:  return 1'b0;
      endcase
   endfunction

   // Constant that cancels every +2^k left by inverted folded bits, plus one
   // unit per complemented carry reinsertion (n-1 CSA stages and the final adder).
   function automatic longint sq_corr_k(input int n);
      longint m;
      longint e;
      m = (longint'(1) << n) + 1;
      e = longint'(n) % m;
      for (int i = 1; i < n; i++)
         if (2 * i >= n) e = (e + (longint'(1) << (2 * i - n))) % m;
      for (int i = 0; i < n; i++)
         for (int j = i + 1; j < n; j++)
            if (i + j + 1 >= n) e = (e + (longint'(1) << (i + j + 1 - n))) % m;
      return (m - e) % m;
   endfunction

endpackage

// File: rtl/sq_ppgen.sv
module sq_ppgen #(
   parameter int N = 8
) (
   input  logic [N:0]              op,
   input  sq_mm_pkg::sq_mode_e     mode,
   output logic [N-1:0][N-1:0]     rows
);
   import sq_mm_pkg::*;

   // Row i holds a_i (weight 2i) and 2*a_i*a_j for j>i (weight i+j+1).
   // These weights never share a column after folding, except a_0 in row 0,
   // which moves to the empty column 0 of the last row.
   always_comb begin
      rows = '0;
      for (int i = 1; i < N; i++) begin
         if (2 * i < N) rows[i][2 * i]     = op[i];
         else           rows[i][2 * i - N] = fold_bit(op[i], mode);
      end
      for (int i = 0; i < N; i++) begin
         for (int j = i + 1; j < N; j++) begin
            if (i + j + 1 < N) rows[i][i + j + 1]     = op[i] & op[j];
            else               rows[i][i + j + 1 - N] = fold_bit(op[i] & op[j], mode);
         end
      end
      // a_n (value 2^n) squares to 1 mod 2^n+1; legal inputs then have a_0 = 0
      rows[N-1][0] = op[0] | ((mode == SQ_PLUS) & op[N]);
   end

endmodule

// File: rtl/sq_csa.sv
module sq_csa #(
   parameter int N = 8
) (
   input  logic [N-1:0]         x,
   input  logic [N-1:0]         y,
   input  logic [N-1:0]         z,
   input  sq_mm_pkg::sq_mode_e  mode,
   output logic [N-1:0]         sum,
   output logic [N-1:0]         cry
);
   import sq_mm_pkg::*;

   logic [N-1:0] maj;
   logic         fb;

   assign sum = x ^ y ^ z;
   assign maj = (x & y) | (x & z) | (y & z);

   // carry-feedback multiplexer: drop / end-around / complemented end-around
   always_comb begin
      case (mode)
         SQ_MINUS: fb = maj[N-1];
         SQ_PLUS:  fb = ~maj[N-1];
         default:  fb = 1'b0;
      endcase
   end

   assign cry = {maj[N-2:0], fb};

endmodule

// File: rtl/sq_tree.sv
module sq_tree #(
   parameter int N = 8
) (
   input  logic [N-1:0][N-1:0]  rows,
   input  logic [N-1:0]         krow,
   input  sq_mm_pkg::sq_mode_e  mode,
   output logic [N-1:0]         sum,
   output logic [N-1:0]         cry
);
   localparam int STAGES = N - 1;   // N partial-product rows plus the constant row

   logic [N-1:0] acc_s [STAGES+1];
   logic [N-1:0] acc_c [STAGES+1];

   assign acc_s[0] = rows[0];
   assign acc_c[0] = rows[1];

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         logic [N-1:0] addend;
         if (k + 2 < N) begin : g_row
            assign addend = rows[k+2];
         end else begin : g_const
            assign addend = krow;
         end
         sq_csa #(.N(N)) u_csa (
            .x    (acc_s[k]),
            .y    (acc_c[k]),
            .z    (addend),
            .mode (mode),
            .sum  (acc_s[k+1]),
            .cry  (acc_c[k+1])
         );
      end
   endgenerate

   assign sum = acc_s[STAGES];
   assign cry = acc_c[STAGES];

endmodule

// File: rtl/sq_endadd.sv
module sq_endadd #(
   parameter int N = 8
) (
   input  logic [N-1:0]         sa,
   input  logic [N-1:0]         ca,
   input  logic                 kin,
   input  sq_mm_pkg::sq_mode_e  mode,
   output logic [N:0]           res
);
   import sq_mm_pkg::*;

   localparam int LG = $clog2(N);

   logic [N-1:0] gg [LG+1];
   logic [N-1:0] pp [LG+1];
   logic [N-1:0] t_low;
   logic         cout;
   logic         rin;
   logic [N:0]   inc;

   assign pp[0] = sa ^ ca;
   assign gg[0] = (sa & ca) | ({{(N-1){1'b0}}, kin} & pp[0]);

   // Sklansky prefix tree
   generate
      for (genvar l = 0; l < LG; l++) begin : g_lvl
         for (genvar i = 0; i < N; i++) begin : g_bit
            if (((i >> l) & 1) == 1) begin : g_mrg
               assign gg[l+1][i] = gg[l][i] | (pp[l][i] & gg[l][((i >> l) << l) - 1]);
               assign pp[l+1][i] = pp[l][i] & pp[l][((i >> l) << l) - 1];
            end else begin : g_pass
               assign gg[l+1][i] = gg[l][i];
               assign pp[l+1][i] = pp[l][i];
            end
         end
      end
   endgenerate

   assign t_low = pp[0] ^ {gg[LG][N-2:0], kin};
   assign cout  = gg[LG][N-1];

   // reinsertion multiplexer on the adder carry-out
   always_comb begin
      case (mode)
         SQ_MINUS: rin = cout;
         SQ_PLUS:  rin = ~cout;
         default:  rin = 1'b0;
      endcase
   end

   assign inc = {1'b0, t_low} + {{N{1'b0}}, rin};

   always_comb begin
      case (mode)
         SQ_RSVD:  res = '0;
         SQ_MINUS: res = (&inc[N-1:0]) ? '0 : inc;
         default:  res = inc;
      endcase
   end

   // R2
   always_comb begin
      if (mode == SQ_MINUS) eac_no_ovf_chk: assert (inc[N] == 1'b0);
   end

endmodule

// File: rtl/sq_multimod.sv
module sq_multimod #(
   parameter int N = 8
) (
   input  logic [1:0]  mod_sel,
   input  logic [N:0]  operand,
   output logic [N:0]  square
);
   import sq_mm_pkg::*;

   generate
      if (N < 3 || N > 30) begin : g_bad_width
         $error("sq_multimod: N must lie between 3 and 30");
      end
   endgenerate

   localparam longint KTOT = sq_corr_k(N);
   localparam longint TOPV = longint'(1) << N;
   localparam logic   KIN  = (KTOT == TOPV);
   localparam logic [N-1:0] KROW = KIN ? {N{1'b1}} : KTOT[N-1:0];

   sq_mode_e            mode;
   logic                is_plus;
   logic [N-1:0][N-1:0] rows;
   logic [N-1:0]        krow;
   logic                kin;
   logic [N-1:0]        t_sum;
   logic [N-1:0]        t_cry;

   assign mode    = sq_mode_e'(mod_sel);
   assign is_plus = (mode == SQ_PLUS);
   assign krow    = is_plus ? KROW : '0;
   assign kin     = is_plus & KIN;

   sq_ppgen #(.N(N)) u_pp (
      .op   (operand),
      .mode (mode),
      .rows (rows)
   );

   sq_tree #(.N(N)) u_tree (
      .rows (rows),
      .krow (krow),
      .mode (mode),
      .sum  (t_sum),
      .cry  (t_cry)
   );

   sq_endadd #(.N(N)) u_add (
      .sa   (t_sum),
      .ca   (t_cry),
      .kin  (kin),
      .mode (mode),
      .res  (square)
   );

   // reference products for the checks below
   localparam logic [2*N+1:0] M1W  = {{(N+2){1'b0}}, {N{1'b1}}};
   localparam logic [2*N+1:0] MPW  = {{(N+1){1'b0}}, 1'b1, {(N-1){1'b0}}, 1'b1};
   localparam logic [N:0]     TOPO = {1'b1, {N{1'b0}}};

   logic [2*N+1:0] lo_sq;
   logic [2*N+1:0] full_sq;
   logic [2*N+1:0] m1_ref;
   logic [2*N+1:0] p1_ref;

   assign lo_sq   = {{(N+2){1'b0}}, operand[N-1:0]} * {{(N+2){1'b0}}, operand[N-1:0]};
   assign full_sq = {{(N+1){1'b0}}, operand} * {{(N+1){1'b0}}, operand};
   assign m1_ref  = lo_sq % M1W;
   assign p1_ref  = full_sq % MPW;

   always_comb begin
      // R1
      if (mode == SQ_POW2) pow2_mode_chk: assert (square == {1'b0, lo_sq[N-1:0]});
      // R2
      if (mode == SQ_MINUS) minus_mode_chk: assert (square == m1_ref[N:0]);
      // R3
      if (is_plus && operand <= TOPO) plus_mode_chk: assert (square == p1_ref[N:0]);
      // R4
      if (mode == SQ_RSVD) rsvd_zero_chk: assert (square == '0);
      // R6
      if (square[N]) top_bit_chk: assert (is_plus && square[N-1:0] == '0);
   end

endmodule

// File: tb/sq_multimod_tb_top.sv
module sq_multimod_tb_top;

   logic clk = 1'b0;
   logic rst_n;
   always #4 clk = ~clk;   // 125 MHz

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   logic [1:0] sel5, sel4;
   logic [5:0] op5,  res5;
   logic [4:0] op4,  res4;

   sq_multimod #(.N(5)) dut_i (
      .mod_sel (sel5),
      .operand (op5),
      .square  (res5)
   );

   sq_multimod #(.N(4)) dut_n4_i (
      .mod_sel (sel4),
      .operand (op4),
      .square  (res4)
   );

   // {select, operand, expected} for n = 5 (moduli 32, 31, 33)
   localparam logic [13:0] VEC5 [12] = '{
      {2'b00, 6'd7,  6'd17},   // R1
      {2'b01, 6'd7,  6'd18},   // R2
      {2'b10, 6'd7,  6'd16},   // R3
      {2'b10, 6'd32, 6'd1},    // R3 operand 2^n
      {2'b01, 6'd31, 6'd0},    // R2 all ones
      {2'b00, 6'd31, 6'd1},    // R1
      {2'b10, 6'd31, 6'd4},    // R3
      {2'b01, 6'd30, 6'd1},    // R2
      {2'b11, 6'd21, 6'd0},    // R4
      {2'b00, 6'd37, 6'd25},   // R5 bit 5 set
      {2'b01, 6'd52, 6'd28},   // R5 bit 5 set
      {2'b10, 6'd0,  6'd0}     // R3
   };

   function automatic longint ref_sq(input int n, input logic [1:0] md, input longint a);
      longint lo;
      lo = a % (longint'(1) << n);
      case (md)
         2'b00:   return (lo * lo) % (longint'(1) << n);
         2'b01:   return (lo * lo) % ((longint'(1) << n) - 1);
         2'b10:   return (a * a) % ((longint'(1) << n) + 1);
         default: return 0;
      endcase
   endfunction

   function automatic string req_tag(input int n, input logic [1:0] md, input longint a);
      bit hi;
      hi = ((a >> n) & 1) == 1;
      case (md)
         2'b00:   return hi ? "R5" : "R1";
         2'b01:   return hi ? "R5" : "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic note(input bit ok, input string tag, input longint act, input longint exp, input string what);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic chk5(input logic [1:0] md, input logic [5:0] a, input longint exp, input string tag);
      sel5 = md;
      op5  = a;
      #2;
      note(res5 == 6'(exp), tag, longint'(res5), exp, "n=5");
      #2;
   endtask

   task automatic chk4(input logic [1:0] md, input logic [4:0] a, input longint exp, input string tag);
      sel4 = md;
      op4  = a;
      #2;
      note(res4 == 5'(exp), tag, longint'(res4), exp, "n=4");
      #2;
   endtask

   initial begin
      rst_n = 1'b0;
      sel5 = 2'b00; op5 = '0;
      sel4 = 2'b00; op4 = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R7 output of the stateless block at reset with a zero operand
      note(res5 == 6'd0, "R7", longint'(res5), 0, "reset n=5");
      note(res4 == 5'd0, "R7", longint'(res4), 0, "reset n=4");
      rst_n = 1'b1;

      foreach (VEC5[v]) begin
         chk5(VEC5[v][13:12], VEC5[v][11:6], longint'(VEC5[v][5:0]),
              req_tag(5, VEC5[v][13:12], longint'(VEC5[v][11:6])));
      end

      // exhaustive sweeps over every select code and operand
      for (int md = 0; md < 4; md++) begin
         for (int a = 0; a < 64; a++) begin
            if (md == 2 && a > 32) continue;
            chk5(2'(md), 6'(a), ref_sq(5, 2'(md), longint'(a)), req_tag(5, 2'(md), longint'(a)));
         end
      end
      for (int md = 0; md < 4; md++) begin
         for (int a = 0; a < 32; a++) begin
            if (md == 2 && a > 16) continue;
            chk4(2'(md), 5'(a), ref_sq(4, 2'(md), longint'(a)), req_tag(4, 2'(md), longint'(a)));
         end
      end

      // directed corner cases
      chk4(2'b10, 5'd4,  16, "R6");   // 16 mod 17 sets output bit n
      chk4(2'b10, 5'd13, 16, "R6");   // 169 mod 17 = 16
      chk4(2'b10, 5'd16, 1,  "R3");   // operand 2^n
      chk4(2'b11, 5'd16, 0,  "R4");
      chk5(2'b01, 6'd63, 0,  "R5");   // all ones with bit n set
      chk5(2'b00, 6'd32, 0,  "R5");   // bit n alone
      // R7 output follows a select change with the operand held
      op5 = 6'd9; sel5 = 2'b00; #2;
      note(res5 == 6'd17, "R7", longint'(res5), 17, "held operand 2^n");
      sel5 = 2'b10; #2;
      note(res5 == 6'd15, "R7", longint'(res5), 15, "held operand 2^n+1");

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule